// File: doc/BRIEF.md
# Phase-Cut Dimmer Trigger Generator

This block turns an 8-bit brightness setpoint into one conduction window per mains half-cycle. The window is timed from a qualified zero-crossing pulse. Each crossing opens a half-cycle. At that crossing the block samples the setpoint, the cut mode and the timing limits. It then times the trigger or release angle from that crossing, using the half-period it measured over the previous half-cycle.

Two cut styles are supported. In leading-edge mode a short gate pulse fires at a delayed angle and the load conducts until the next crossing, which suits a thyristor-type switch. In trailing-edge mode the gate is held on from the crossing and released at the angle, which suits a MOSFET pair. The angle is kept out of a guard zone next to each crossing, and the conduction window is never shorter than a programmable floor. The outputs stay off until the supply is good, the reference is valid and a half-period has been measured. If either condition drops during operation, the gate is cut at once.

Top module: `dim_trigger_gen`

## Requirements
- R1: After reset, `gate_o` and `window_o` are low. They stay low until both `supply_good_i` and `ref_valid_i` are high at one crossing (measurement starts) and again at the next crossing (the block runs from that half-cycle on). Every cycle before that is low.
- R2: The half-period P is the number of clock edges from one crossing edge to the next. The angle in a half-cycle uses the P measured over the half-cycle that just ended.
- R3: Let G be the guard length, M the minimum window and L the level. Then E = max(G, M), span = P - G - E, and off = span when L = 255, otherwise floor(span*L/256). The leading angle is A = P - E - off; the trailing angle is A = E + off.
- R4: Edge 0 is the edge that samples the crossing, and output sample c is the value after edge c. In leading mode (`mode_i` = 0), the gate is high exactly for the c with A <= c-1 < A + W and c-1 < P - G, where W is the pulse width. So the pulse is cut short before the next guard zone.
- R5: In leading mode, `window_o` is high for every c >= A+1 up to the end of the half-cycle. The gate is never high while the window is low.
- R6: In trailing mode (`mode_i` = 1), `gate_o` and `window_o` are both high exactly for c = 1..A.
- R7: The trigger or release angle always satisfies G <= A <= P - G, including when G exceeds M.
- R8: In leading mode A <= P - M, and in trailing mode A >= M. This also holds when M exceeds G.
- R9: When G + E > P, the half-cycle has no gate or window activity.
- R10: Changes to the level or mode during a half-cycle have no effect until the next crossing.
- R11: When `ref_valid_i` goes low during operation, both outputs are low from the next edge on. The block again needs two valid crossings before it drives anything.
- R12: Both outputs are low at sample c = 0 of every half-cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zc_i | input | 1 | Qualified crossing pulse, one clock wide |
| ref_valid_i | input | 1 | Crossing reference is trustworthy |
| supply_good_i | input | 1 | Supply rails are in range |
| mode_i | input | 1 | 0 = leading-edge cut, 1 = trailing-edge cut |
| level_i | input | LVL_W | Brightness setpoint, 255 = brightest |
| guard_i | input | CNT_W | Guard zone length in clocks on each side of a crossing |
| min_win_i | input | CNT_W | Minimum conduction window in clocks |
| pulse_w_i | input | CNT_W | Leading-edge gate pulse width in clocks |
| gate_o | output | 1 | Gate drive |
| window_o | output | 1 | Expected conduction window marker |

## Verification
The assertions assume that `zc_i` is a clean single-clock pulse with at most one pulse per half-cycle. They also assume that half-periods are far below the range of the phase counter, so measured periods never saturate. The stimulus keeps to this: it issues exactly one one-clock crossing pulse per half-cycle and uses half-periods of 40 to 80 clocks. It changes all inputs only on falling clock edges, so every configuration value is settled when a crossing samples it.

// File: rtl/dim_pkg.sv
package dim_pkg;
  typedef enum logic {
    MODE_LEAD  = 1'b0,
    MODE_TRAIL = 1'b1
  } cut_mode_e;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_MEAS = 2'd1,
    ST_RUN  = 2'd2
  } sync_st_e;
endpackage

// File: rtl/dim_halfcycle_timer.sv
module dim_halfcycle_timer
  import dim_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zc_i,
  input  logic             ok_i,
  input  logic [LVL_W-1:0] level_i,
  input  cut_mode_e        mode_i,
  input  logic [CNT_W-1:0] guard_i,
  input  logic [CNT_W-1:0] minw_i,
  input  logic [CNT_W-1:0] pw_i,
  output logic [CNT_W-1:0] phase_o,
  output logic [CNT_W-1:0] period_o,
  output logic             run_o,
  output logic [LVL_W-1:0] lvl_o,
  output cut_mode_e        mode_o,
  output logic [CNT_W-1:0] guard_o,
  output logic [CNT_W-1:0] minw_o,
  output logic [CNT_W-1:0] pw_o
);
  localparam logic [CNT_W-1:0] PH_MAX = '1;

  sync_st_e         state_q;
  logic [CNT_W-1:0] phase_q;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] phase_inc;

  assign phase_inc = (phase_q == PH_MAX) ? PH_MAX : phase_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_WAIT;
      phase_q  <= '0;
      period_q <= '0;
      lvl_o    <= '0;
      mode_o   <= MODE_LEAD;
      guard_o  <= '0;
      minw_o   <= '0;
      pw_o     <= '0;
    end else begin
      if (zc_i) begin
        phase_q <= '0;
        lvl_o   <= level_i;
        mode_o  <= mode_i;
        guard_o <= guard_i;
        minw_o  <= minw_i;
        pw_o    <= pw_i;
        if (state_q != ST_WAIT) period_q <= phase_inc;
      end else begin
        phase_q <= phase_inc;
      end

      if (!ok_i) begin
        state_q <= ST_WAIT;
      end else if (zc_i) begin
        case (state_q)
          ST_WAIT: state_q <= ST_MEAS;
          ST_MEAS: state_q <= ST_RUN;
          default: state_q <= ST_RUN;
        endcase
      end
    end
  end

  assign phase_o  = phase_q;
  assign period_o = period_q;
  assign run_o    = (state_q == ST_RUN);

  AST_SETPOINT_HELD: assert property (@(posedge clk) disable iff (rst)
    !zc_i |=> $stable(lvl_o) && $stable(mode_o)); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_MAX) |=> (phase_o == PH_MAX) || (phase_o == '0)); // R2

  AST_RUN_NEEDS_OK: assert property (@(posedge clk) disable iff (rst)
    !ok_i |=> !run_o); // R11
endmodule

// File: rtl/dim_angle_map.sv
module dim_angle_map
  import dim_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LVL_W = 8
) (
  input  logic [CNT_W-1:0] period_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  cut_mode_e        mode_i,
  input  logic [CNT_W-1:0] guard_i,
  input  logic [CNT_W-1:0] minw_i,
  output logic [CNT_W-1:0] ang_o,
  output logic             en_o
);
  localparam int W1 = CNT_W + 1;
  localparam int PW = CNT_W + LVL_W;
  localparam logic [LVL_W-1:0] LVL_FULL = '1;

  logic [CNT_W-1:0] edge_lim;
  logic [W1-1:0]    lim_sum;
  logic [CNT_W-1:0] span;
  logic [PW-1:0]    prod;
  logic [CNT_W-1:0] off;

  assign edge_lim = (guard_i > minw_i) ? guard_i : minw_i;
  assign lim_sum  = {1'b0, guard_i} + {1'b0, edge_lim};
  assign en_o     = (lim_sum <= {1'b0, period_i});
  assign span     = CNT_W'({1'b0, period_i} - lim_sum);
  assign prod     = PW'(span) * PW'(lvl_i);
  assign off      = (lvl_i == LVL_FULL) ? span : CNT_W'(prod >> LVL_W);

  always_comb begin
    if (!en_o) begin
      ang_o = '0;
    end else if (mode_i == MODE_LEAD) begin
      ang_o = period_i - edge_lim - off;
    end else begin
      ang_o = edge_lim + off;
    end
  end
endmodule

// File: rtl/dim_gate_shaper.sv
module dim_gate_shaper
  import dim_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zc_i,
  input  logic             ok_i,
  input  logic             run_i,
  input  logic             en_i,
  input  cut_mode_e        mode_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] guard_i,
  input  logic [CNT_W-1:0] minw_i,
  input  logic [CNT_W-1:0] pw_i,
  input  logic [CNT_W-1:0] ang_i,
  output logic             gate_o,
  output logic             win_o
);
  localparam int W1 = CNT_W + 1;

  logic [W1-1:0] k, a, p_end, g_lim;
  logic          lead_fire, lead_win, trail_on, active;

  assign k         = {1'b0, phase_i};
  assign a         = {1'b0, ang_i};
  assign p_end     = a + {1'b0, pw_i};
  assign g_lim     = {1'b0, period_i} - {1'b0, guard_i};
  assign lead_fire = (k >= a) && (k < p_end) && (k < g_lim);
  assign lead_win  = (k >= a);
  assign trail_on  = (k < a);
  assign active    = ok_i && run_i && en_i && !zc_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_o <= 1'b0;
      win_o  <= 1'b0;
    end else if (!active) begin
      gate_o <= 1'b0;
      win_o  <= 1'b0;
    end else if (mode_i == MODE_LEAD) begin
      gate_o <= lead_fire;
      win_o  <= lead_win;
    end else begin
      gate_o <= trail_on;
      win_o  <= trail_on;
    end
  end

  AST_OFF_WHEN_INVALID: assert property (@(posedge clk) disable iff (rst)
    !ok_i |=> !gate_o && !win_o); // R11

  AST_OFF_BEFORE_RUN: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !gate_o && !win_o); // R1

  AST_GATE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    gate_o |-> win_o); // R5

  AST_ANGLE_IN_GUARD: assert property (@(posedge clk) disable iff (rst)
    en_i |-> (ang_i >= guard_i) && (a + {1'b0, guard_i} <= {1'b0, period_i})); // R7

  AST_MIN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    en_i |-> ((mode_i == MODE_LEAD) ? (a + {1'b0, minw_i} <= {1'b0, period_i})
                                    : (ang_i >= minw_i))); // R8

  AST_PULSE_CLEAR_OF_GUARD: assert property (@(posedge clk) disable iff (rst)
    gate_o && (mode_i == MODE_LEAD) |-> (k + {1'b0, guard_i} <= {1'b0, period_i})); // R4
endmodule

// File: rtl/dim_trigger_gen.sv
module dim_trigger_gen
  import dim_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zc_i,
  input  logic             ref_valid_i,
  input  logic             supply_good_i,
  input  logic             mode_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [CNT_W-1:0] guard_i,
  input  logic [CNT_W-1:0] min_win_i,
  input  logic [CNT_W-1:0] pulse_w_i,
  output logic             gate_o,
  output logic             window_o
);
  logic             ok;
  logic [CNT_W-1:0] phase, period, guard_q, minw_q, pw_q, ang;
  logic [LVL_W-1:0] lvl_q;
  cut_mode_e        mode_q;
  logic             run, en;

  assign ok = supply_good_i && ref_valid_i;

  dim_halfcycle_timer #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .zc_i     (zc_i),
    .ok_i     (ok),
    .level_i  (level_i),
    .mode_i   (cut_mode_e'(mode_i)),
    .guard_i  (guard_i),
    .minw_i   (min_win_i),
    .pw_i     (pulse_w_i),
    .phase_o  (phase),
    .period_o (period),
    .run_o    (run),
    .lvl_o    (lvl_q),
    .mode_o   (mode_q),
    .guard_o  (guard_q),
    .minw_o   (minw_q),
    .pw_o     (pw_q)
  );

  dim_angle_map #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_map (
    .period_i (period),
    .lvl_i    (lvl_q),
    .mode_i   (mode_q),
    .guard_i  (guard_q),
    .minw_i   (minw_q),
    .ang_o    (ang),
    .en_o     (en)
  );

  dim_gate_shaper #(.CNT_W(CNT_W)) u_shaper (
    .clk      (clk),
    .rst      (rst),
    .zc_i     (zc_i),
    .ok_i     (ok),
    .run_i    (run),
    .en_i     (en),
    .mode_i   (mode_q),
    .phase_i  (phase),
    .period_i (period),
    .guard_i  (guard_q),
    .minw_i   (minw_q),
    .pw_i     (pw_q),
    .ang_i    (ang),
    .gate_o   (gate_o),
    .win_o    (window_o)
  );
endmodule

// File: tb/dim_trigger_gen_tb.sv
module dim_trigger_gen_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic zc = 1'b0, refv = 1'b0, sup = 1'b0, md = 1'b0;
  logic [7:0]  lvl = 8'd0;
  logic [15:0] g = 16'd4, m = 16'd10, pw = 16'd5;
  logic gate, win;

  int total = 0, bad = 0;
  int st = 0;        // bench model: 0 wait, 1 measuring, 2 running
  int prev_len = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dim_trigger_gen u_dut (
    .clk(clk), .rst(rst), .zc_i(zc), .ref_valid_i(refv), .supply_good_i(sup),
    .mode_i(md), .level_i(lvl), .guard_i(g), .min_win_i(m), .pulse_w_i(pw),
    .gate_o(gate), .window_o(win)
  );

  function automatic int angle(int p, int gg, int mm, int l, bit mode, output bit en);
    int e, span, off;
    e = (gg > mm) ? gg : mm;
    en = (gg + e <= p);
    if (!en) return 0;
    span = p - gg - e;
    off = (l == 255) ? span : (span * l) / 256;
    return mode ? e + off : p - e - off;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One half-cycle of len clocks. Entered and left at a falling edge.
  task automatic half(int len, int l, bit mode, string tg, string tw,
                      int alt_at = -1, int drop_at = -1);
    bit en, run;
    int a, k, eg, ew, gerr, werr, fc, fga, fge;
    lvl = l[7:0]; md = mode; zc = 1'b1;
    if (!(sup && refv)) st = 0;
    else if (st < 2) st++;
    run = (st == 2);
    a = angle(prev_len, int'(g), int'(m), l, mode, en);
    gerr = 0; werr = 0; fc = -1; fga = 0; fge = 0;
    for (int c = 0; c < len; c++) begin
      @(posedge clk); @(negedge clk);
      if (c == 0) zc = 1'b0;
      eg = 0; ew = 0;
      if (run && en && c > 0 && !(drop_at >= 0 && c > drop_at)) begin
        k = c - 1;
        if (!mode) begin
          eg = (k >= a && k < a + int'(pw) && k < prev_len - int'(g)) ? 1 : 0;
          ew = (k >= a) ? 1 : 0;
        end else begin
          eg = (k < a) ? 1 : 0;
          ew = eg;
        end
      end
      if (int'(gate) != eg) begin
        gerr++;
        if (fc < 0) begin fc = c; fga = int'(gate); fge = eg; end
      end
      if (int'(win) != ew) werr++;
      if (c == alt_at) begin lvl = ~lvl; md = ~md; end
      if (c == drop_at) begin refv = 1'b0; st = 0; end
    end
    check(tg, gerr, 0, $sformatf("gate mismatches len=%0d lvl=%0d mode=%0d first c=%0d gate=%0d exp=%0d",
                                 len, l, mode, fc, fga, fge));
    check(tw, werr, 0, $sformatf("window mismatches len=%0d lvl=%0d mode=%0d", len, l, mode));
    prev_len = len;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1", int'(gate), 0, "gate after reset");
    check("R1", int'(win), 0, "window after reset");

    // R1: crossings without a good supply do nothing
    for (int i = 0; i < 3; i++) half(60, 200, 0, "R1", "R1");
    sup = 1'b1; refv = 1'b1;
    half(60, 200, 0, "R1", "R1");            // measuring half
    // R3 / R5 / R8: full leading sweep, M > G
    for (int l = 0; l < 256; l++) half(60, l, 0, "R3", "R5");
    // R6 / R8: full trailing sweep
    for (int l = 0; l < 256; l++) half(60, l, 1, "R6", "R8");

    // R7 / R4: G > M, wide pulse cut short before guard
    g = 16'd12; m = 16'd3; pw = 16'd40;
    for (int l = 0; l < 256; l += 15) begin
      half(80, l, 0, "R4", "R7");
      half(80, l, 1, "R7", "R12");
    end

    // R9: guard plus edge limit exceed the half-period
    g = 16'd20; m = 16'd25; pw = 16'd5;
    for (int i = 0; i < 4; i++) half(40, 128, i % 2, "R9", "R9");

    // R2: alternating half-periods use the previous measurement
    g = 16'd4; m = 16'd8;
    for (int i = 0; i < 6; i++) half((i % 2) ? 70 : 50, 128, i / 3, "R2", "R2");

    // R10: mid-half changes of level and mode are ignored
    for (int i = 0; i < 4; i++) half(60, 40 + 50 * i, i % 2, "R10", "R10", 5 + 9 * i);

    // R11: reference loss mid-half, then resync over two crossings
    half(60, 230, 0, "R11", "R11", -1, 30);
    refv = 1'b1;
    half(60, 230, 0, "R11", "R11");           // measuring again, no output
    half(60, 230, 0, "R11", "R11");
    half(60, 100, 1, "R11", "R11", -1, 10);
    refv = 1'b1;
    half(60, 100, 1, "R11", "R11");
    half(60, 100, 1, "R11", "R11");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule